// File: doc/BRIEF.md
# Twelve-Round Permutation Engine with Direct Memory Access

This block runs the complete twelve-round permutation on a 320-bit state of five 64-bit lanes that sits in memory. Software hands it a byte pointer through a start pulse. The engine then handles all of the traffic for that state by itself. It reads the five lanes over a 32-bit request/response port and applies one round per clock through a single round datapath. It writes the result back to the same address and raises a one-cycle completion pulse. The processor never loads or stores the lanes.

Each round has three steps. First it folds a round-dependent byte into lane 2. Then it applies the five-bit substitution, bit-sliced across the lanes. Last, each lane is mixed with two rotated copies of itself. The engine sits next to a processor pipeline as a custom-instruction accelerator. Decode, arbitration and coherence are handled by the logic around it.

Top module: `perm12_engine`

## Requirements
- R1: While reset is asserted and right after it, busy_o, done_o and mem_req_o are all 0.
- R2: After an accepted start, the engine issues exactly ten read beats with mem_we_o=0 at addresses ptr, ptr+4, ..., ptr+36, in ascending order. Lane i occupies bytes ptr+8i to ptr+8i+7, little-endian, and its low 32 bits are moved first.
- R3: Round r (r = 0 to 11) XORs the byte {4'hF-r, r} into the least significant byte of lane 2 before substitution. The schedule is therefore 0xF0, 0xE1, ..., 0x4B.
- R4: The state written back equals twelve applications of the round to the fetched state. A round is: constant addition (R3); the substitution x0^=x4, x4^=x3, x2^=x1, then t_i = x_i ^ (~x_{i+1} & x_{i+2}) with indices taken mod 5, then t1^=t0, t0^=t4, t3^=t2, t2=~t2; then the diffusion lane_i = t_i ^ ror(t_i,a_i) ^ ror(t_i,b_i), where (a,b) is (19,28), (61,39), (1,6), (10,17), (7,41) for lanes 0 to 4.
- R5: Write-back issues ten beats with mem_we_o=1 to the same ten addresses in the same order as the reads. The first write request appears exactly 13 cycles after the cycle in which the last read is acknowledged, which leaves one cycle per round.
- R6: busy_o goes high in the cycle after an accepted start and stays high until the last write acknowledge. done_o is high for exactly one cycle, the cycle after that acknowledge, and busy_o is low while done_o is high.
- R7: A start pulse while busy_o is high is ignored. The operation in flight keeps its pointer and result, and no second operation follows.
- R8: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o hold their values.
- R9: mem_req_o is low whenever busy_o is low and during the twelve round cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when busy_o is low |
| ptr_i | input | 32 | Byte address of lane 0, 4-byte aligned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr_o | output | 32 | Byte address of the beat |
| mem_wdata_o | output | 32 | Write data of the beat |
| mem_ack_i | input | 1 | Beat accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench compares the written-back memory image against its own twelve-round model. It uses all-zero and all-one states as well as random states. A wrong constant schedule or a misplaced rotation would show up there as corrupted lanes. The memory model stalls acknowledges at random. A design that let its address or data drift during a stall, or that advanced on an unacknowledged beat, would write to the wrong place or fetch the wrong halves. The bench also measures the read-to-write gap and where the done pulse falls, which catches a round count off by one and a done or busy that is early or stretched. A start injected during the rounds must not move the target address or launch a second fetch.

// File: rtl/perm12_pkg.sv
package perm12_pkg;
  localparam int LANES   = 5;
  localparam int LANE_W  = 64;
  localparam int BUS_W   = 32;
  localparam int STATE_W = LANES * LANE_W;
  localparam int MAX_RND = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ROUND,
    ST_WBACK,
    ST_DONE
  } eng_state_e;

  // Round byte: upper nibble counts down from 0xF, lower nibble counts up.
  function automatic logic [7:0] round_byte(input logic [3:0] idx);
    return {4'hF - idx, idx};
  endfunction
endpackage

// File: rtl/perm12_round.sv
module perm12_round
  import perm12_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  logic [7:0]         rc_i,
  output logic [STATE_W-1:0] st_o
);
  localparam int ROT_A [LANES] = '{19, 61, 1, 10, 7};
  localparam int ROT_B [LANES] = '{28, 39, 6, 17, 41};

  logic [LANE_W-1:0] x [LANES];
  logic [LANE_W-1:0] a [LANES];
  logic [LANE_W-1:0] t [LANES];
  logic [LANE_W-1:0] u [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) x[i] = st_i[LANE_W*i +: LANE_W];
    // constant addition and input mixing
    a[0] = x[0] ^ x[4];
    a[1] = x[1];
    a[2] = x[2] ^ {{(LANE_W-8){1'b0}}, rc_i} ^ x[1];
    a[3] = x[3];
    a[4] = x[4] ^ x[3];
    // chi-like core
    for (int i = 0; i < LANES; i++)
      t[i] = a[i] ^ (~a[(i+1) % LANES] & a[(i+2) % LANES]);
    // output mixing
    u[0] = t[0] ^ t[4];
    u[1] = t[1] ^ t[0];
    u[2] = ~t[2];
    u[3] = t[3] ^ t[2];
    u[4] = t[4];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_diff
    localparam int RA = ROT_A[g];
    localparam int RB = ROT_B[g];
    logic [LANE_W-1:0] rot_a, rot_b;
    assign rot_a = {u[g][RA-1:0], u[g][LANE_W-1:RA]};
    assign rot_b = {u[g][RB-1:0], u[g][LANE_W-1:RB]};
    assign st_o[LANE_W*g +: LANE_W] = u[g] ^ rot_a ^ rot_b;
  end
endmodule

// File: rtl/perm12_beat_seq.sv
module perm12_beat_seq #(
  parameter int BEATS = 10,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              advance_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == BEAT_W'(BEATS - 1));
  assign beat_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)        cnt_d = '0;
    else if (advance_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/perm12_ctrl.sv
module perm12_ctrl
  import perm12_pkg::*;
#(
  parameter int ROUNDS = 12,
  localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             xfer_i,
  input  logic             beat_last_i,
  output eng_state_e       state_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             accept_o
);
  eng_state_e       st_q, st_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             rnd_last;

  assign rnd_last = (rnd_q == RND_W'(ROUNDS - 1));
  assign accept_o = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign state_o  = st_q;
  assign rnd_o    = rnd_q;

  always_comb begin
    st_d  = st_q;
    rnd_d = '0;
    case (st_q)
      ST_IDLE:  if (accept_o) st_d = ST_FETCH;
      ST_FETCH: if (xfer_i && beat_last_i) st_d = ST_ROUND;
      ST_ROUND: begin
        rnd_d = rnd_q + 1'b1;
        if (rnd_last) begin
          st_d  = ST_WBACK;
          rnd_d = '0;
        end
      end
      ST_WBACK: if (xfer_i && beat_last_i) st_d = ST_DONE;
      ST_DONE:  st_d = accept_o ? ST_FETCH : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rnd_q <= '0;
    end else begin
      st_q  <= st_d;
      rnd_q <= rnd_d;
    end
  end
endmodule

// File: rtl/perm12_engine.sv
module perm12_engine
  import perm12_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROUNDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BUS_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [BUS_W-1:0]  mem_rdata_i
);
  localparam int BEATS     = STATE_W / BUS_W;
  localparam int BEAT_W    = $clog2(BEATS);
  localparam int RND_W     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int FIRST_IDX = MAX_RND - ROUNDS;

  eng_state_e        state;
  logic [RND_W-1:0]  rnd;
  logic              accept;
  logic              xfer;
  logic [BEAT_W-1:0] beat;
  logic              beat_last;
  logic [ADDR_W-1:0] ptr_q;
  logic [STATE_W-1:0] st_q, st_next;
  logic [7:0]        rc;
  logic              load_half, load_round;
  logic [BUS_W-1:0]  halves [BEATS];

  perm12_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .xfer_i      (xfer),
    .beat_last_i (beat_last),
    .state_o     (state),
    .rnd_o       (rnd),
    .accept_o    (accept)
  );

  perm12_beat_seq #(.BEATS(BEATS)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept),
    .advance_i (xfer),
    .beat_o    (beat),
    .last_o    (beat_last)
  );

  assign rc = round_byte(4'(FIRST_IDX) + 4'(rnd));

  perm12_round u_round (
    .st_i (st_q),
    .rc_i (rc),
    .st_o (st_next)
  );

  assign busy_o    = (state == ST_FETCH) || (state == ST_ROUND) || (state == ST_WBACK);
  assign done_o    = (state == ST_DONE);
  assign mem_req_o = (state == ST_FETCH) || (state == ST_WBACK);
  assign mem_we_o  = (state == ST_WBACK);
  assign xfer      = mem_req_o && mem_ack_i;
  assign load_half  = xfer && (state == ST_FETCH);
  assign load_round = (state == ST_ROUND);

  for (genvar g = 0; g < BEATS; g++) begin : g_half
    assign halves[g] = st_q[BUS_W*g +: BUS_W];
  end

  assign mem_addr_o  = ptr_q + (ADDR_W'(beat) << 2);
  assign mem_wdata_o = halves[beat];

  // pointer register: loaded only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (accept) ptr_q <= ptr_i;
  end

  // state register: half-word fill during fetch, full update per round
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (load_round) begin
      st_q <= st_next;
    end else if (load_half) begin
      for (int k = 0; k < BEATS; k++)
        if (beat == BEAT_W'(k)) st_q[BUS_W*k +: BUS_W] <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/perm12_engine_chk.sv
module perm12_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] ptr_q
);
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 4));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  assert_ptr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(ptr_q)));
endmodule

bind perm12_engine perm12_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .ptr_q       (ptr_q)
);

// File: tb/perm12_engine_test.sv
module perm12_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] ptr = '0;
  logic        busy, done, req, we, ack = 0;
  logic [31:0] addr, wdata, rdata;

  logic [31:0] mem [0:63];
  int checks = 0, fails = 0, ncyc = 0;
  int stall_pct = 0;
  int rd_n, wr_n, last_rd, last_wr, first_wr, done_cyc, done_cnt, idle_req, extra_rd;
  logic [31:0] rd_addr [10];
  logic [31:0] wr_addr [10];

  always #4 clk = ~clk;

  perm12_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ptr_i(ptr),
    .busy_o(busy), .done_o(done), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata)
  );

  assign rdata = mem[addr[7:2]];

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // memory model and transfer log, all at the falling edge
  always @(negedge clk) begin
    logic a;
    ncyc++;
    if (ncyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", ncyc);
      summary();
      $finish;
    end
    if (!busy && req) idle_req++;
    if (done) begin
      done_cnt++;
      if (done_cyc < 0) done_cyc = ncyc;
    end
    if (req && we && first_wr < 0) first_wr = ncyc;
    if (req && !we && rd_n >= 10) extra_rd++;
    a = req && (($urandom % 100) >= stall_pct);
    if (a) begin
      if (we) begin
        mem[addr[7:2]] = wdata;
        if (wr_n < 10) wr_addr[wr_n] = addr;
        wr_n++;
        last_wr = ncyc;
      end else begin
        if (rd_n < 10) rd_addr[rd_n] = addr;
        rd_n++;
        last_rd = ncyc;
      end
    end
    ack = a;
  end

  function automatic logic [63:0] ror(input logic [63:0] v, input int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic logic [319:0] model(input logic [319:0] s);
    logic [63:0] x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
    {x4, x3, x2, x1, x0} = s;
    for (int r = 0; r < 12; r++) begin
      x2 = x2 ^ {56'd0, 4'(15 - r), 4'(r)};
      x0 = x0 ^ x4; x4 = x4 ^ x3; x2 = x2 ^ x1;
      t0 = x0 ^ (~x1 & x2); t1 = x1 ^ (~x2 & x3); t2 = x2 ^ (~x3 & x4);
      t3 = x3 ^ (~x4 & x0); t4 = x4 ^ (~x0 & x1);
      t1 = t1 ^ t0; t0 = t0 ^ t4; t3 = t3 ^ t2; t2 = ~t2;
      x0 = t0 ^ ror(t0, 19) ^ ror(t0, 28);
      x1 = t1 ^ ror(t1, 61) ^ ror(t1, 39);
      x2 = t2 ^ ror(t2, 1)  ^ ror(t2, 6);
      x3 = t3 ^ ror(t3, 10) ^ ror(t3, 17);
      x4 = t4 ^ ror(t4, 7)  ^ ror(t4, 41);
    end
    return {x4, x3, x2, x1, x0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [319:0] act,
                       input logic [319:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 random, 1 zeros, 2 ones; poke: start pulse during rounds
  task automatic run_op(input logic [31:0] p, input int stall, input int kind, input bit poke);
    logic [319:0] init, exp, got;
    int base, n;
    bit ok;
    base = int'(p[7:2]);
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    for (int k = 0; k < 10; k++) begin
      if (kind == 1) mem[base + k] = '0;
      if (kind == 2) mem[base + k] = '1;
      init[32*k +: 32] = mem[base + k];
    end
    exp = model(init);
    @(negedge clk); #1;
    rd_n = 0; wr_n = 0; last_rd = -1; last_wr = -1; first_wr = -1;
    done_cyc = -1; done_cnt = 0; idle_req = 0; extra_rd = 0;
    stall_pct = stall;
    start = 1; ptr = p;
    @(negedge clk); #1;
    start = 0; ptr = '0;
    check(busy === 1'b1, "R6 busy after start", 320'(busy), 320'(1));
    if (poke) begin
      n = 0;
      while (rd_n < 10 && n < 3000) begin @(negedge clk); #1; n++; end
      start = 1; ptr = p ^ 32'h80;
      @(negedge clk); #1;
      start = 0;
    end
    n = 0;
    while (done_cyc < 0 && n < 3000) begin @(negedge clk); #1; n++; end
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1; end
    for (int k = 0; k < 10; k++) got[32*k +: 32] = mem[base + k];
    check(got === exp, "R4 R3 written-back state", got, exp);
    ok = (rd_n == 10);
    for (int k = 0; k < 10; k++) if (rd_addr[k] !== p + 32'(4 * k)) ok = 0;
    check(ok, "R2 read beat order", 320'(rd_n), 320'(10));
    ok = (wr_n == 10);
    for (int k = 0; k < 10; k++) if (wr_addr[k] !== p + 32'(4 * k)) ok = 0;
    check(ok, "R5 R7 write beat addresses", 320'(wr_n), 320'(10));
    check(first_wr - last_rd == 13, "R5 read-to-write gap", 320'(first_wr - last_rd), 320'(13));
    check(done_cyc == last_wr + 1, "R6 done position", 320'(done_cyc), 320'(last_wr + 1));
    check(done_cnt == 1, "R6 R7 single done pulse", 320'(done_cnt), 320'(1));
    check(idle_req == 0 && extra_rd == 0 && busy === 1'b0, "R9 R7 no stray requests",
          320'(idle_req + extra_rd), 320'(0));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rd_n = 0; wr_n = 0; done_cyc = -1; done_cnt = 0; idle_req = 0; extra_rd = 0;
    last_rd = -1; last_wr = -1; first_wr = -1;
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0, "R1 busy in reset", 320'(busy), 320'(0));
    check(done === 1'b0, "R1 done in reset", 320'(done), 320'(0));
    check(req === 1'b0, "R1 req in reset", 320'(req), 320'(0));
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    check(busy === 1'b0 && req === 1'b0, "R1 idle after reset", 320'({busy, req}), 320'(0));
    run_op(32'h0000_0010, 0, 1, 0);
    run_op(32'h0000_0044, 70, 2, 0);
    run_op(32'h0000_0000, 0, 0, 0);
    run_op(32'h0000_00D8, 50, 0, 0);
    run_op(32'h0000_0020, 30, 0, 1);
    for (int i = 0; i < 8; i++)
      run_op(32'(($urandom % 55) * 4), int'($urandom % 80), 0, i[0]);
    summary();
    $finish;
  end
endmodule